// File: doc/BRIEF.md
# PLL Control Register Sequencer

This block owns the 32-bit control word that sets the PLL dividers and decides what the rest of the chip goes through when software rewrites that word. At power-on it loads divider settings picked by two strap pins. A later write carries two control bits. When both bits are 1, the new divider values glide in with no disturbance. When either bit is 0, the block raises a chip-reset request, stalls the core until the PLL reports lock, or does both.

The stored word comes through the reset that the block itself requests. Boot code can therefore read the register back, see that its settings are already in place, and carry on instead of writing them again. The strap defaults are reloaded only by the power-on reset input. The PLL's lock and reset-done indications come in as plain inputs. The divider fields go out as separate buses.

Top module: `pll_cfg_sequencer`

## Requirements
- R1: While `por_n` is low, the register loads from `mode_sel`, always with input divider 0, output divider 1 and both control bits 1. The multiplier field is 159 for mode 00, 15 for mode 01, 31 for mode 10 and 63 for mode 11. For example, mode 11 reads back 0xC0803F00.
- R2: Word layout: input divider in bits [6:0], multiplier in bits [20:8], output divider in bits [25:23], hold-for-lock bit (active low) in bit 30, reset-on-change bit (active low) in bit 31. `pll_div_in`, `pll_mult` and `pll_div_out` show these fields from the cycle after an accepted write.
- R3: An accepted write with bits 31 and 30 both 1 updates the fields and raises neither `chip_rst_req` nor `core_stall`.
- R4: An accepted write with bit 31 at 0 raises `chip_rst_req` in the cycle after the write, with the new fields already on the outputs. The request stays high for exactly 16 cycles.
- R5: After a reset request ends, `core_stall` stays high until `rst_done` is sampled high. The block then goes idle, or waits for lock when bit 30 of the stored word is 0.
- R6: An accepted write with bit 30 at 0 keeps `core_stall` high. The stall is released only after `pll_lock` has been sampled high on 4 consecutive clock edges in the lock-wait phase. A low sample restarts the count.
- R7: The stored word keeps its written value through a reset request the block raised. Changing `mode_sel` then reloads nothing.
- R8: A write while a sequence is running (`core_stall` high) is ignored.
- R9: Bits outside the defined fields always read back as 0, and any value written to them is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| mode_sel | input | 2 | Strap pins choosing the power-on settings |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word to write |
| cfg_rd_data | output | 32 | Stored control word, unused bits zero |
| pll_lock | input | 1 | Lock indication from the PLL |
| rst_done | input | 1 | Chip reset has completed |
| pll_div_in | output | 7 | Input divider field |
| pll_mult | output | 13 | Multiplier field |
| pll_div_out | output | 3 | Output divider field |
| chip_rst_req | output | 1 | Chip reset request |
| core_stall | output | 1 | Holds the core while a sequence runs |

## Verification
The bench measures the reset pulse cycle by cycle. A pulse one cycle short or one cycle long would show up as a wrong count. It drives a lock pattern with a single low glitch after three high samples. A filter that does not restart its count would release the stall too early. It changes the strap pins during a self-requested reset and writes during a running sequence. A design that reloaded the defaults, or that accepted the busy write, would read back a value other than the one written. Random glide writes with reserved bits set catch a readback that leaks those bits or a field placed at the wrong position.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int WORD_W   = 32;
  localparam int R_W      = 7;
  localparam int F_W      = 13;
  localparam int OD_W     = 3;
  localparam int R_LSB    = 0;
  localparam int F_LSB    = 8;
  localparam int OD_LSB   = 23;
  localparam int HOLD_BIT = 30;
  localparam int RST_BIT  = 31;

  typedef struct packed {
    logic            rst_n;
    logic            lock_n;
    logic [OD_W-1:0] od;
    logic [F_W-1:0]  f;
    logic [R_W-1:0]  r;
  } cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RST,
    SEQ_DONE_WAIT,
    SEQ_LOCK_WAIT
  } seq_state_e;

  function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.r      = w[R_LSB +: R_W];
    c.f      = w[F_LSB +: F_W];
    c.od     = w[OD_LSB +: OD_W];
    c.lock_n = w[HOLD_BIT];
    c.rst_n  = w[RST_BIT];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[R_LSB +: R_W]   = c.r;
    w[F_LSB +: F_W]   = c.f;
    w[OD_LSB +: OD_W] = c.od;
    w[HOLD_BIT]       = c.lock_n;
    w[RST_BIT]        = c.rst_n;
    return w;
  endfunction

  function automatic logic [F_W-1:0] boot_mult(input logic [1:0] mode);
    logic [F_W-1:0] f;
    case (mode)
      2'b00:   f = F_W'(159);
      2'b01:   f = F_W'(15);
      2'b10:   f = F_W'(31);
      default: f = F_W'(63);
    endcase
    return f;
  endfunction

  function automatic cfg_t boot_cfg(input logic [1:0] mode);
    cfg_t c;
    c.rst_n  = 1'b1;
    c.lock_n = 1'b1;
    c.od     = OD_W'(1);
    c.f      = boot_mult(mode);
    c.r      = '0;
    return c;
  endfunction

endpackage

// File: rtl/pllseq_cfg_reg.sv
module pllseq_cfg_reg
  import pllseq_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic [1:0]        mode_sel,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output cfg_t              cfg_q
);

  // Only the power-on reset touches the strap defaults; a requested
  // chip reset never reaches this register.
  always_ff @(posedge clk) begin
    if (!por_n) begin
      cfg_q <= boot_cfg(mode_sel);
    end else if (load) begin
      cfg_q <= word_to_cfg(load_word);
    end
  end

endmodule

// File: rtl/pllseq_lock_filter.sv
module pllseq_lock_filter #(
  parameter int LOCK_RUN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  input  logic lock,
  output logic qualified
);

  localparam int RUN_W = (LOCK_RUN > 1) ? $clog2(LOCK_RUN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

  logic [RUN_W-1:0] run_q;

  assign qualified = en && lock && (run_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (!por_n || !en || !lock || qualified) begin
      run_q <= '0;
    end else begin
      run_q <= run_q + RUN_W'(1);
    end
  end

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_accept,
  input  logic       wr_rst_n,
  input  logic       wr_lock_n,
  input  logic       held_lock_n,
  input  logic       rst_done,
  input  logic       lock_ok,
  output seq_state_e state_o,
  output logic       chip_rst_req,
  output logic       core_stall,
  output logic       lock_en,
  output logic       seq_idle
);

  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(RST_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] pulse_q;
  logic             pulse_end;

  assign pulse_end = (pulse_q == PULSE_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: begin
        if (wr_accept) begin
          if (!wr_rst_n)       state_d = SEQ_RST;
          else if (!wr_lock_n) state_d = SEQ_LOCK_WAIT;
        end
      end
      SEQ_RST:       if (pulse_end) state_d = SEQ_DONE_WAIT;
      SEQ_DONE_WAIT: if (rst_done)  state_d = held_lock_n ? SEQ_IDLE : SEQ_LOCK_WAIT;
      SEQ_LOCK_WAIT: if (lock_ok)   state_d = SEQ_IDLE;
      default:                      state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      state_q <= SEQ_IDLE;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_q == SEQ_RST && !pulse_end) ? pulse_q + CNT_W'(1) : '0;
    end
  end

  assign state_o      = state_q;
  assign chip_rst_req = (state_q == SEQ_RST);
  assign core_stall   = (state_q != SEQ_IDLE);
  assign lock_en      = (state_q == SEQ_LOCK_WAIT);
  assign seq_idle     = (state_q == SEQ_IDLE);

endmodule

// File: rtl/pll_cfg_sequencer.sv
module pll_cfg_sequencer
  import pllseq_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int LOCK_RUN   = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [1:0]        mode_sel,
  input  logic              cfg_wr_en,
  input  logic [WORD_W-1:0] cfg_wr_data,
  output logic [WORD_W-1:0] cfg_rd_data,
  input  logic              pll_lock,
  input  logic              rst_done,
  output logic [R_W-1:0]    pll_div_in,
  output logic [F_W-1:0]    pll_mult,
  output logic [OD_W-1:0]   pll_div_out,
  output logic              chip_rst_req,
  output logic              core_stall
);

  // Named internal events, observed by the bound checker.
  logic       wr_accept;
  logic       seq_idle;
  logic       lock_en;
  logic       lock_ok;
  cfg_t       cfg_q;
  cfg_t       wr_cfg;
  seq_state_e seq_state;

  assign wr_cfg    = word_to_cfg(cfg_wr_data);
  assign wr_accept = cfg_wr_en && seq_idle;

  pllseq_cfg_reg u_cfg (
    .clk       (clk),
    .por_n     (por_n),
    .mode_sel  (mode_sel),
    .load      (wr_accept),
    .load_word (cfg_wr_data),
    .cfg_q     (cfg_q)
  );

  pllseq_lock_filter #(.LOCK_RUN(LOCK_RUN)) u_lock (
    .clk       (clk),
    .por_n     (por_n),
    .en        (lock_en),
    .lock      (pll_lock),
    .qualified (lock_ok)
  );

  pllseq_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk          (clk),
    .por_n        (por_n),
    .wr_accept    (wr_accept),
    .wr_rst_n     (wr_cfg.rst_n),
    .wr_lock_n    (wr_cfg.lock_n),
    .held_lock_n  (cfg_q.lock_n),
    .rst_done     (rst_done),
    .lock_ok      (lock_ok),
    .state_o      (seq_state),
    .chip_rst_req (chip_rst_req),
    .core_stall   (core_stall),
    .lock_en      (lock_en),
    .seq_idle     (seq_idle)
  );

  assign cfg_rd_data = cfg_to_word(cfg_q);
  assign pll_div_in  = cfg_q.r;
  assign pll_mult    = cfg_q.f;
  assign pll_div_out = cfg_q.od;

endmodule

// File: rtl/pllseq_checker.sv
module pllseq_checker
  import pllseq_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int LOCK_RUN   = 4
) (
  input logic              clk,
  input logic              por_n,
  input logic              cfg_wr_en,
  input logic [WORD_W-1:0] cfg_wr_data,
  input logic [WORD_W-1:0] cfg_rd_data,
  input logic              wr_accept,
  input logic              seq_idle,
  input logic              pll_lock,
  input logic [R_W-1:0]    pll_div_in,
  input logic [F_W-1:0]    pll_mult,
  input logic [OD_W-1:0]   pll_div_out,
  input logic              chip_rst_req,
  input logic              core_stall
);

  localparam logic [WORD_W-1:0] LIVE_MASK = cfg_to_word(cfg_t'('1));
  localparam int LEN_W = $clog2(RST_CYCLES + 2) + 1;
  localparam int RUN_W = $clog2(LOCK_RUN + 1) + 1;

  logic [LEN_W-1:0] rst_len;
  logic [RUN_W-1:0] lock_run;

  always_ff @(posedge clk) begin
    if (!por_n || !chip_rst_req) rst_len <= '0;
    else if (rst_len < LEN_W'(RST_CYCLES + 1)) rst_len <= rst_len + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!por_n || !pll_lock) lock_run <= '0;
    else if (lock_run < RUN_W'(LOCK_RUN)) lock_run <= lock_run + RUN_W'(1);
  end

  a_r2_fields_follow_write: assert property (@(posedge clk) disable iff (!por_n)
    wr_accept |=> (pll_div_in == $past(cfg_wr_data[R_LSB +: R_W])) &&
                  (pll_mult == $past(cfg_wr_data[F_LSB +: F_W])) &&
                  (pll_div_out == $past(cfg_wr_data[OD_LSB +: OD_W])));

  a_r3_glide_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (wr_accept && cfg_wr_data[RST_BIT] && cfg_wr_data[HOLD_BIT]) |=> (!chip_rst_req && !core_stall));

  a_r4_reset_follows_write: assert property (@(posedge clk) disable iff (!por_n)
    (wr_accept && !cfg_wr_data[RST_BIT]) |=> chip_rst_req);

  a_r4_pulse_not_long: assert property (@(posedge clk) disable iff (!por_n)
    chip_rst_req |-> (rst_len < LEN_W'(RST_CYCLES)));

  a_r4_pulse_exact: assert property (@(posedge clk) disable iff (!por_n)
    $fell(chip_rst_req) |-> (rst_len == LEN_W'(RST_CYCLES)));

  a_r5_stall_after_pulse: assert property (@(posedge clk) disable iff (!por_n)
    $fell(chip_rst_req) |-> core_stall);

  a_r6_stall_on_hold_write: assert property (@(posedge clk) disable iff (!por_n)
    (wr_accept && !cfg_wr_data[HOLD_BIT]) |=> core_stall);

  a_r6_lock_run_before_release: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(core_stall) && !cfg_rd_data[HOLD_BIT]) |-> (lock_run >= RUN_W'(LOCK_RUN)));

  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr_en && !seq_idle) |=> $stable(cfg_rd_data));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_rd_data & ~LIVE_MASK) == '0);

endmodule

bind pll_cfg_sequencer pllseq_checker #(
  .RST_CYCLES (RST_CYCLES),
  .LOCK_RUN   (LOCK_RUN)
) u_pllseq_chk (
  .clk          (clk),
  .por_n        (por_n),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_wr_data  (cfg_wr_data),
  .cfg_rd_data  (cfg_rd_data),
  .wr_accept    (wr_accept),
  .seq_idle     (seq_idle),
  .pll_lock     (pll_lock),
  .pll_div_in   (pll_div_in),
  .pll_mult     (pll_mult),
  .pll_div_out  (pll_div_out),
  .chip_rst_req (chip_rst_req),
  .core_stall   (core_stall)
);

// File: tb/pll_cfg_sequencer_tb_top.sv
module pll_cfg_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        por_n;
  logic [1:0]  mode_sel;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        pll_lock;
  logic        rst_done;
  logic [6:0]  pll_div_in;
  logic [12:0] pll_mult;
  logic [2:0]  pll_div_out;
  logic        chip_rst_req;
  logic        core_stall;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [31:0] MASK = 32'hC39F_FF7F;

  always #5 clk = ~clk;

  pll_cfg_sequencer dut_i (
    .clk(clk), .por_n(por_n), .mode_sel(mode_sel),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .pll_lock(pll_lock), .rst_done(rst_done),
    .pll_div_in(pll_div_in), .pll_mult(pll_mult), .pll_div_out(pll_div_out),
    .chip_rst_req(chip_rst_req), .core_stall(core_stall)
  );

  function automatic logic [31:0] exp_boot(input logic [1:0] m);
    logic [12:0] f;
    f = (m == 2'b00) ? 13'd159 : (m == 2'b01) ? 13'd15 : (m == 2'b10) ? 13'd31 : 13'd63;
    return {2'b11, 4'b0, 3'd1, 2'b0, f, 1'b0, 7'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_fields(input logic [31:0] w, input string req);
    chk(pll_div_in == w[6:0],   req, 32'(pll_div_in),  32'(w[6:0]));
    chk(pll_mult == w[20:8],    req, 32'(pll_mult),    32'(w[20:8]));
    chk(pll_div_out == w[25:23], req, 32'(pll_div_out), 32'(w[25:23]));
  endtask

  task automatic write_word(input logic [31:0] d);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  // Full sequence for any control-bit combination, checked from R3..R7.
  task automatic run_word(input logic [31:0] d);
    logic [31:0] e;
    int n;
    e = d & MASK;
    pll_lock = d[30];
    write_word(d);
    chk(cfg_rd_data == e, "R9 readback masked", cfg_rd_data, e);
    chk_fields(d, "R2 fields");
    if (!d[31]) begin
      chk(chip_rst_req == 1'b1, "R4 request raised", 32'(chip_rst_req), 1);
      n = 0;
      while (chip_rst_req && n < 40) begin n++; @(negedge clk); end
      chk(n == 16, "R4 pulse length", n, 16);
      repeat (2) begin
        chk(core_stall && !chip_rst_req, "R5 stall until done", 32'(core_stall), 1);
        @(negedge clk);
      end
      rst_done = 1'b1;
      @(negedge clk);
      rst_done = 1'b0;
    end else begin
      chk(chip_rst_req == 1'b0, "R3 no request", 32'(chip_rst_req), 0);
    end
    if (!d[30]) begin
      chk(core_stall == 1'b1, "R6 stall held for lock", 32'(core_stall), 1);
      pll_lock = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk(core_stall == 1'b1, "R6 stall before 4 lock samples", 32'(core_stall), 1);
      end
      @(negedge clk);
      chk(core_stall == 1'b0, "R6 stall released", 32'(core_stall), 0);
    end else begin
      chk(core_stall == 1'b0, "R3 R5 no stall", 32'(core_stall), 0);
    end
    chk(cfg_rd_data == e, "R7 value kept", cfg_rd_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    void'($urandom(32'd20250611));
    por_n = 1'b0; mode_sel = 2'b11; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    pll_lock = 1'b1; rst_done = 1'b0;

    // R1: power-on defaults for every strap value.
    for (int m = 0; m < 4; m++) begin
      por_n = 1'b0;
      mode_sel = 2'(m);
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      chk(cfg_rd_data == exp_boot(2'(m)), "R1 boot word", cfg_rd_data, exp_boot(2'(m)));
      chk_fields(exp_boot(2'(m)), "R1 boot fields");
      chk(!chip_rst_req && !core_stall, "R1 quiet after reset", {chip_rst_req, core_stall}, 0);
    end

    // R3/R9: random glide writes, reserved bits filled at random.
    for (int i = 0; i < 30; i++) begin
      d = $urandom;
      d[31:30] = 2'b11;
      run_word(d);
      @(negedge clk);
      chk(!chip_rst_req && !core_stall, "R3 still quiet", {chip_rst_req, core_stall}, 0);
    end

    // Directed: every control-bit combination.
    run_word(32'h0100_7C00);
    run_word(32'h4100_2A05);
    run_word(32'h8180_1F03);

    // R7/R8 and lock glitch: busy write, strap change, glitchy lock.
    held = 32'h0200_3101;
    pll_lock = 1'b0;
    write_word(held);
    write_word(32'hC000_0001);
    chk(cfg_rd_data == held, "R8 write during pulse ignored", cfg_rd_data, held);
    chk_fields(held, "R8 fields unchanged");
    mode_sel = 2'b00;
    while (chip_rst_req) @(negedge clk);
    rst_done = 1'b1;
    @(negedge clk);
    rst_done = 1'b0;
    chk(cfg_rd_data == held, "R7 no reload after own reset", cfg_rd_data, held);
    pll_lock = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(core_stall == 1'b1, "R6 stall during first run", 32'(core_stall), 1);
    end
    pll_lock = 1'b0;
    @(negedge clk);
    chk(core_stall == 1'b1, "R6 stall at glitch", 32'(core_stall), 1);
    write_word(32'hC000_0002);
    chk(cfg_rd_data == held, "R8 write during lock wait ignored", cfg_rd_data, held);
    pll_lock = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(core_stall == 1'b1, "R6 count restarted", 32'(core_stall), 1);
    end
    @(negedge clk);
    chk(core_stall == 1'b0, "R6 release after 4 samples", 32'(core_stall), 0);
    chk(cfg_rd_data == held, "R7 value after sequence", cfg_rd_data, held);

    // Random mix of control bits.
    for (int i = 0; i < 8; i++) begin
      run_word($urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule